// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. Both phases are first resynchronised to the local clock. A programmable divider then sets how often the synchronised pair is sampled. On each sample, the previous 2-bit phase state and the new one together form a 4-bit index. A fixed decode of that index decides whether the count moves up one, moves down one or holds.

A host never reads the counter directly. It writes a request word into a small request queue. When the block takes a nonzero word from that queue, it places a snapshot of the count in a response queue, which the host pops when it is ready. A zero word is consumed and produces nothing. If the response queue is full, the request waits at the head of the request queue while counting carries on. The snapshot is taken at the moment the request is finally served.

Top module: `quad_position_counter`

## Requirements
- R1: The phase state is {phaseA, phaseB}. The transitions 00→10, 10→11, 11→01 and 01→00 each raise the count by one at the sample that sees them.
- R2: The transitions 00→01, 01→11, 11→10 and 10→00 each lower the count by one.
- R3: A sample equal to the previous state leaves the count unchanged. So does a sample that differs from it in both bits (00↔11, 01↔10).
- R4: The count is CNT_W bits wide (default 32) and wraps in two's complement. One step up from the largest positive value gives the most negative value, and one step down from zero gives all ones.
- R5: A nonzero request word taken from the request queue pushes the current count into the response queue. The response is visible (rspEmpty low, rspData at the head) two clock edges after the edge that wrote the request, provided the response queue has room.
- R6: A request word of zero is removed from the request queue and produces no response.
- R7: With divSel = 0 the phases are sampled on every clock. With divSel = N > 0 they are sampled once every N+1 clocks, and the count changes only on a sample.
- R8: While the response queue is full, a nonzero request stays pending at the head of the request queue and counting continues. Once space frees up, the request is served with the count at that time.
- R9: Reset clears the count and both queues. After reset the previous state is loaded from the first synchronised sample, so a phase level that is not 00 is never counted as a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| divSel | input | DIV_W | Sample divider: 0 means every clock, N means every N+1 clocks |
| reqWrEn | input | 1 | Write strobe for the request queue (ignored while reqFull) |
| reqData | input | REQ_W | Request word; nonzero asks for a count snapshot |
| reqFull | output | 1 | Request queue full |
| rspRdEn | input | 1 | Pop strobe for the response queue (ignored while rspEmpty) |
| rspData | output | CNT_W | Count snapshot at the head of the response queue |
| rspEmpty | output | 1 | Response queue empty |

## Verification
The bench builds the block with CNT_W = 8 and both queue depths at 2, and keeps the 16-bit divider. The narrow count lets 128 forward steps carry the count across the signed boundary from +127 to -128, which makes the R4 wrap reachable in a short run. The shallow response queue fills after two requests, so a third request shows the pending-and-late-snapshot behaviour of R8. A divider of 3 against inputs that change every clock shows that samples are spaced four clocks apart: the count then ends unchanged, where sampling on every clock counts every step.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic loadPrev;  // capture the first settled phase state after reset
    logic sampleEn;  // sample phases and apply the decoded step
    logic popReq;    // consume the head of the request queue
    logic pushRsp;   // write the count snapshot into the response queue
  } qpc_strobe_t;

  // idx = {previous state, new state}, each state = {phaseA, phaseB}
  function automatic step_e decodeStep(input logic [3:0] idx);
    step_e s;
    case (idx)
      4'b0010, 4'b1011, 4'b1101, 4'b0100: s = STEP_UP;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: s = STEP_DOWN;
      default:                            s = STEP_HOLD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/qpc_fifo.sv
module qpc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;
  logic         doPush, doPop;

  assign full    = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign empty   = (wrPtr == rdPtr);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  AST_FIFO_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) <= (AW+1)'(DEPTH)); // R5

  AST_FIFO_RESET_EMPTY: assert property (@(posedge clk)
    !rstN |=> empty); // R9

endmodule

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic             reqEmpty,
  input  logic             reqNonZero,
  input  logic             rspFull,
  output qpc_strobe_t      strb
);
  localparam logic [1:0] SETTLE_CYCLES = 2'd2;

  logic [1:0]       fillCnt;
  logic             primed;
  logic [DIV_W-1:0] divCnt;
  logic             tick;

  // Divider: one tick every divSel+1 clocks, every clock when divSel is 0
  assign tick = (divCnt >= divSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      primed  <= 1'b0;
      divCnt  <= '0;
    end else begin
      if (!primed) begin
        if (fillCnt == SETTLE_CYCLES) primed  <= 1'b1;
        else                          fillCnt <= fillCnt + 1'b1;
      end
      if (tick) divCnt <= '0;
      else      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadPrev = !primed && (fillCnt == SETTLE_CYCLES);
    strb.sampleEn = primed && tick;
    // a zero word is always consumable; a nonzero word waits for room
    strb.popReq   = !reqEmpty && (!reqNonZero || !rspFull);
    strb.pushRsp  = strb.popReq && reqNonZero;
  end

  AST_ZERO_DIV_EVERY_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (primed && divSel == '0) |-> strb.sampleEn); // R7

  AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sampleEn && divSel != '0) |=> (divSel == '0 || !strb.sampleEn)); // R7

  AST_RSP_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushRsp |-> !rspFull); // R8

  AST_REQ_HELD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (!reqEmpty && reqNonZero && rspFull) |-> !strb.popReq); // R8

  AST_ZERO_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popReq && !reqNonZero) |-> !strb.pushRsp); // R6

  AST_PRIME_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPrev |=> !strb.loadPrev); // R9

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  qpc_strobe_t      strb,
  output logic [CNT_W-1:0] countQ
);
  logic [1:0] syncMeta, syncState, prevState;
  step_e      stepSel;

  assign stepSel = decodeStep({prevState, syncState});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta  <= '0;
      syncState <= '0;
      prevState <= '0;
      countQ    <= '0;
    end else begin
      syncMeta  <= {phaseA, phaseB};
      syncState <= syncMeta;
      if (strb.loadPrev || strb.sampleEn) prevState <= syncState;
      if (strb.sampleEn) begin
        case (stepSel)
          STEP_UP:   countQ <= countQ + 1'b1;
          STEP_DOWN: countQ <= countQ - 1'b1;
          default:   countQ <= countQ;
        endcase
      end
    end
  end

  AST_COUNT_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleEn |=> $stable(countQ)); // R7

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleEn |=> (countQ == $past(countQ) || countQ == $past(countQ) + CNT_W'(1)
                       || countQ == $past(countQ) - CNT_W'(1))); // R1

  AST_DOUBLE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sampleEn && ((prevState ^ syncState) == 2'b11)) |=> $stable(countQ)); // R3

  AST_SAME_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sampleEn && (prevState == syncState)) |=> $stable(countQ)); // R3

  AST_PRIME_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPrev |=> (countQ == '0)); // R9

endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int REQ_W     = 32,
  parameter int DIV_W     = 16,
  parameter int REQ_DEPTH = 4,
  parameter int RSP_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic [DIV_W-1:0] divSel,
  input  logic             reqWrEn,
  input  logic [REQ_W-1:0] reqData,
  output logic             reqFull,
  input  logic             rspRdEn,
  output logic [CNT_W-1:0] rspData,
  output logic             rspEmpty
);
  qpc_strobe_t      strb;
  logic [REQ_W-1:0] reqHead;
  logic             reqEmpty, rspFull;
  logic [CNT_W-1:0] countQ;

  qpc_fifo #(.W(REQ_W), .DEPTH(REQ_DEPTH)) u_reqQ (
    .clk(clk), .rstN(rstN),
    .push(reqWrEn), .pushData(reqData),
    .pop(strb.popReq), .popData(reqHead),
    .full(reqFull), .empty(reqEmpty)
  );

  qpc_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divSel(divSel),
    .reqEmpty(reqEmpty), .reqNonZero(|reqHead), .rspFull(rspFull),
    .strb(strb)
  );

  qpc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .strb(strb), .countQ(countQ)
  );

  qpc_fifo #(.W(CNT_W), .DEPTH(RSP_DEPTH)) u_rspQ (
    .clk(clk), .rstN(rstN),
    .push(strb.pushRsp), .pushData(countQ),
    .pop(rspRdEn), .popData(rspData),
    .full(rspFull), .empty(rspEmpty)
  );

endmodule

// File: tb/sim_quad_position_counter.sv
module sim_quad_position_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  typedef struct packed {
    logic [1:0]           ph;
    logic [3:0]           req;
    logic signed [CW-1:0] exp;
  } vec_t;

  // forward: 00->10->11->01->00 (R1); reverse (R2); hold / double step (R3)
  localparam vec_t VEC [17] = '{
    '{2'b10, 4'd1,  8'sd1}, '{2'b11, 4'd1,  8'sd2}, '{2'b01, 4'd1,  8'sd3},
    '{2'b00, 4'd1,  8'sd4}, '{2'b01, 4'd2,  8'sd3}, '{2'b11, 4'd2,  8'sd2},
    '{2'b10, 4'd2,  8'sd1}, '{2'b00, 4'd2,  8'sd0}, '{2'b00, 4'd3,  8'sd0},
    '{2'b11, 4'd3,  8'sd0}, '{2'b00, 4'd3,  8'sd0}, '{2'b01, 4'd2, -8'sd1},
    '{2'b10, 4'd3, -8'sd1}, '{2'b00, 4'd2, -8'sd2}, '{2'b10, 4'd1, -8'sd1},
    '{2'b01, 4'd3, -8'sd1}, '{2'b11, 4'd2, -8'sd2}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          phaseA = 1'b0, phaseB = 1'b0;
  logic [15:0]   divSel = '0;
  logic          reqWrEn = 1'b0;
  logic [31:0]   reqData = '0;
  logic          reqFull;
  logic          rspRdEn = 1'b0;
  logic [CW-1:0] rspData;
  logic          rspEmpty;

  int  applied = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic [1:0] ph = 2'b00;

  quad_position_counter #(.CNT_W(CW), .REQ_W(32), .DIV_W(16),
                          .REQ_DEPTH(2), .RSP_DEPTH(2)) u0 (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB), .divSel(divSel),
    .reqWrEn(reqWrEn), .reqData(reqData), .reqFull(reqFull),
    .rspRdEn(rspRdEn), .rspData(rspData), .rspEmpty(rspEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] nextFwd(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] expv);
    applied++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic setPh(input logic [1:0] s);
    ph = s;
    phaseA = s[1];
    phaseB = s[0];
  endtask

  task automatic sendReq(input logic [31:0] w);
    @(negedge clk);
    reqData = w;
    reqWrEn = 1'b1;
    @(negedge clk);
    reqWrEn = 1'b0;
  endtask

  task automatic popRsp(output logic [CW-1:0] v);
    for (int i = 0; i < 20 && rspEmpty; i++) @(negedge clk);
    v = rspData;
    rspRdEn = 1'b1;
    @(negedge clk);
    rspRdEn = 1'b0;
  endtask

  task automatic readCount(output logic [CW-1:0] v);
    sendReq(32'd1);
    popRsp(v);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fastFwd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      setPh(nextFwd(ph));
    end
  endtask

  initial begin
    logic [CW-1:0] v, c0;
    setPh(2'b00);
    waitClk(4);
    @(negedge clk) rstN = 1'b1;
    check("R9 reset rspEmpty", CW'(rspEmpty), CW'(1));
    check("R9 reset reqFull", CW'(reqFull), CW'(0));
    waitClk(5);

    // vector table: one step per entry, count read back through the queues
    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      setPh(VEC[i].ph);
      waitClk(5);
      readCount(v);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
    end

    // R5: response timing, exactly two edges after the write edge
    @(negedge clk);
    reqData = 32'h100; reqWrEn = 1'b1;
    @(negedge clk);
    reqWrEn = 1'b0;
    check("R5 not yet visible", CW'(rspEmpty), CW'(1));
    @(negedge clk);
    check("R5 visible after two edges", CW'(rspEmpty), CW'(0));
    check("R5 snapshot value", rspData, CW'(-2));
    popRsp(v);

    // R6: zero request is consumed silently
    sendReq(32'd0);
    waitClk(6);
    check("R6 zero word no response", CW'(rspEmpty), CW'(1));
    check("R6 queue drained", CW'(reqFull), CW'(0));

    // R7: every-clock sampling counts 40 fast steps
    readCount(c0);
    fastFwd(40);
    waitClk(6);
    readCount(v);
    check("R7 divSel=0 fast steps", v, c0 + CW'(40));

    // R7: divider 3 sees a 4-periodic input as constant
    divSel = 16'd3;
    waitClk(8);
    readCount(c0);
    fastFwd(40);
    waitClk(12);
    readCount(v);
    check("R7 divSel=3 aliased fast input", v, c0);

    // R7: steps held exactly four clocks are each seen once
    readCount(c0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      setPh(nextFwd(ph));
      waitClk(3);
    end
    waitClk(12);
    readCount(v);
    check("R7 divSel=3 slow steps", v, c0 + CW'(8));
    divSel = 16'd0;
    waitClk(4);

    // R8: full response queue holds the third request pending
    readCount(c0);
    sendReq(32'd5);
    sendReq(32'd6);
    sendReq(32'd7);
    @(negedge clk);
    setPh(nextFwd(ph));
    waitClk(8);
    popRsp(v);
    check("R8 first queued snapshot", v, c0);
    popRsp(v);
    check("R8 second queued snapshot", v, c0);
    popRsp(v);
    check("R8 pending served with later count", v, c0 + CW'(1));

    // R9: reset with a nonzero phase level, pending response discarded
    sendReq(32'd1);
    waitClk(2);
    @(negedge clk);
    rstN = 1'b0;
    setPh(2'b10);
    waitClk(3);
    @(negedge clk) rstN = 1'b1;
    check("R9 response queue cleared", CW'(rspEmpty), CW'(1));
    waitClk(10);
    readCount(v);
    check("R9 no spurious step from level 10", v, CW'(0));

    // R4: wrap across the signed boundary with the narrow count
    fastFwd(127);
    waitClk(6);
    readCount(v);
    check("R4 largest positive", v, 8'h7F);
    fastFwd(1);
    waitClk(6);
    readCount(v);
    check("R4 wraps to most negative", v, 8'h80);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

endmodule